// File: doc/BRIEF.md
# Integer Result Flag Generator

This unit sits behind a 64-bit integer execute stage. For each finished instruction it gets the source operands, an optional immediate and the 64-bit result. From these it works out the carry, overflow and summary-overflow status bits and a 4-bit condition field. The status bits live in registers inside the block. They change only on the single-cycle update pulse that marks an instruction's completion, and each group of bits has its own enable.

Carry is not taken from an adder carry-out. Instead, every operand taking part is compared, as an unsigned number, against the result, and a carry is reported when any operand is larger. The same test is repeated on the low halves to give the 32-bit carry. Overflow compares the signs of the first two operands with the sign of the result, at the full width and at the low half. A divider can bypass that rule by supplying its own overflow indication. The summary-overflow bit is sticky, and the condition field records the sign class of the result together with the summary-overflow bit.

Top module: `int_flag_gen`

## Requirements
- R1: While `rst_n` is low, `ca_o`, `ca32_o`, `ov_o`, `ov32_o`, `so_o` and `cr0_o` are all zero.
- R2: The operand list holds `src_a`, `src_b` and `src_c`, in that order, limited to the first `src_cnt` of them. When `imm_vld` is 1, `imm_val` is appended as a further entry. When `inv_first` is 1, `src_a` is bitwise inverted before any flag is computed.
- R3: On an update (`upd_en`=1, `carry_en`=1, `done_mask[0]`=0), `ca_o` becomes 1 if any list entry, taken as an unsigned 64-bit value, is greater than `result`, and 0 otherwise.
- R4: Under the same conditions with `done_mask[1]`=0, `ca32_o` follows the same rule using only bits 31:0 of each entry and of `result`.
- R5: `done_mask[0]`=1 leaves `ca_o` unchanged, and `done_mask[1]`=1 leaves `ca32_o` unchanged; the two work independently. `carry_en`=0 leaves both unchanged.
- R6: The overflow rule looks at the first two list entries X and Y. On an overflow update, `ov_o` is 1 exactly when bit 63 of X equals bit 63 of Y and bit 63 of `result` differs from them. `ov32_o` uses the same rule on bit 31.
- R7: When `div_vld`=1, an overflow update writes `div_ovf` into both `ov_o` and `ov32_o`, whatever the operands are.
- R8: When the list has fewer than two entries and `div_vld`=0, `ov_o`, `ov32_o` and `so_o` are left unchanged.
- R9: Overflow bits are updated only when `upd_en`, `oe_en` and `oe_vld` are all 1.
- R10: On every overflow update, `so_o` becomes its previous value ORed with the new `ov_o`. Once set, it stays set until reset.
- R11: On an update with `rc_en`=1, `cr0_o` is loaded as {negative, positive, zero, SO}, with bit 3 first. The sign classes come from `result` read as a signed value. The SO bit is the value of `so_o` after that same update. Exactly one of bits 3:1 is set.
- R12: With `upd_en`=0, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | One-cycle pulse per completed instruction |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| src_c | input | 64 | Third source operand |
| src_cnt | input | 2 | Number of source operands taking part (0 to 3) |
| inv_first | input | 1 | Invert src_a before flag computation |
| imm_vld | input | 1 | Immediate takes part as an extra operand |
| imm_val | input | 64 | Immediate value |
| result | input | 64 | Execute-stage result |
| div_vld | input | 1 | Divider overflow indication present |
| div_ovf | input | 1 | Divider overflow value |
| carry_en | input | 1 | Instruction writes carry bits |
| oe_en | input | 1 | Overflow enable |
| oe_vld | input | 1 | Overflow enable is meaningful |
| rc_en | input | 1 | Record form: update condition field |
| done_mask | input | 2 | Bit 0: carry already produced; bit 1: 32-bit carry already produced |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | 32-bit carry |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | 32-bit overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field {negative, positive, zero, SO} |

## Verification
Sign overflow seldom shows up on uniform random operands. It is hardest to reach when the full-width and half-width overflows disagree, because the result must then cross a sign boundary in one half but not the other. Directed steps use results placed just past 0x7FFF...F and just past 0x7FFFFFFF to cover this. Random steps often set the result to the true sum of the first two entries, with operand sign bits forced the same, so that both overflow bits are exercised together with the sticky SO chain. The pairing rule for the second overflow entry (src_b, or the immediate when only one source is present) is covered by varying `src_cnt` and `imm_vld` throughout the run.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  typedef struct packed {
    logic so;
    logic ov32;
    logic ov;
    logic ca32;
    logic ca;
  } ifg_flags_t;

  localparam int IFG_DONE_CA   = 0;
  localparam int IFG_DONE_CA32 = 1;

endpackage

// File: rtl/ifg_operand_list.sv
module ifg_operand_list #(
  parameter  int XLEN = 64,
  parameter  int NSRC = 3,
  localparam int CNTW = $clog2(NSRC + 1),
  localparam int NENT = NSRC + 1
) (
  input  logic [NSRC-1:0][XLEN-1:0] src,
  input  logic [CNTW-1:0]           src_cnt,
  input  logic                      inv_first,
  input  logic                      imm_vld,
  input  logic [XLEN-1:0]           imm,
  output logic [NENT-1:0][XLEN-1:0] ent,
  output logic [NENT-1:0]           ent_vld,
  output logic [XLEN-1:0]           pair_x,
  output logic [XLEN-1:0]           pair_y,
  output logic                      pair_ok
);

  // source slots: prefix of src_cnt entries, first one optionally inverted
  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    if (g == 0) begin : g_first
      assign ent[g] = inv_first ? ~src[g] : src[g];
    end else begin : g_rest
      assign ent[g] = src[g];
    end
    assign ent_vld[g] = (src_cnt > CNTW'(g));
  end

  // immediate is the last slot
  assign ent[NSRC]     = imm;
  assign ent_vld[NSRC] = imm_vld;

  // pick the first two valid entries for the sign-overflow rule
  always_comb begin
    int hits;
    hits   = 0;
    pair_x = '0;
    pair_y = '0;
    for (int i = 0; i < NENT; i++) begin
      if (ent_vld[i]) begin
        if (hits == 0) begin
          pair_x = ent[i];
        end else if (hits == 1) begin
          pair_y = ent[i];
        end
        if (hits < 2) begin
          hits = hits + 1;
        end
      end
    end
    pair_ok = (hits == 2);
  end

endmodule

// File: rtl/ifg_carry_detect.sv
module ifg_carry_detect #(
  parameter int XLEN = 64,
  parameter int NENT = 4,
  parameter int CW   = 64
) (
  input  logic [NENT-1:0][XLEN-1:0] ent,
  input  logic [NENT-1:0]           ent_vld,
  input  logic [XLEN-1:0]           res,
  output logic                      carry
);

  logic [NENT-1:0] above;

  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    assign above[i] = ent_vld[i] && (ent[i][CW-1:0] > res[CW-1:0]);
  end

  assign carry = |above;

endmodule

// File: rtl/ifg_ovf_detect.sv
module ifg_ovf_detect #(
  parameter  int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] pair_x,
  input  logic [XLEN-1:0] pair_y,
  input  logic            pair_ok,
  input  logic [XLEN-1:0] res,
  input  logic            div_vld,
  input  logic            div_ovf,
  output logic            ov_full,
  output logic            ov_half,
  output logic            ov_known
);

  logic [1:0] ov_w;

  // index 0: full width, index 1: low half
  for (genvar w = 0; w < 2; w++) begin : g_width
    localparam int SB = (w == 0) ? XLEN - 1 : HALF - 1;
    logic sign_rule;
    assign sign_rule = pair_ok && (pair_x[SB] == pair_y[SB]) && (res[SB] != pair_x[SB]);
    assign ov_w[w]   = div_vld ? div_ovf : sign_rule;
  end

  assign ov_full  = ov_w[0];
  assign ov_half  = ov_w[1];
  assign ov_known = div_vld | pair_ok;

endmodule

// File: rtl/ifg_cr_form.sv
module ifg_cr_form #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] res,
  input  logic            so_in,
  output logic [3:0]      cr
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = res[XLEN-1];
  assign is_zero = (res == '0);
  assign cr      = {is_neg, ~is_neg & ~is_zero, is_zero, so_in};

endmodule

// File: rtl/int_flag_gen.sv
module int_flag_gen
  import ifg_pkg::*;
#(
  parameter  int XLEN = 64,
  localparam int NSRC = 3,
  localparam int NENT = NSRC + 1,
  localparam int CNTW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] src_c,
  input  logic [CNTW-1:0] src_cnt,
  input  logic            inv_first,
  input  logic            imm_vld,
  input  logic [XLEN-1:0] imm_val,
  input  logic [XLEN-1:0] result,
  input  logic            div_vld,
  input  logic            div_ovf,
  input  logic            carry_en,
  input  logic            oe_en,
  input  logic            oe_vld,
  input  logic            rc_en,
  input  logic [1:0]      done_mask,
  output logic            ca_o,
  output logic            ca32_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            so_o,
  output logic [3:0]      cr0_o
);

  logic [NSRC-1:0][XLEN-1:0] src_vec;
  logic [NENT-1:0][XLEN-1:0] ent;
  logic [NENT-1:0]           ent_vld;
  logic [XLEN-1:0]           pair_x;
  logic [XLEN-1:0]           pair_y;
  logic                      pair_ok;
  logic                      carry_full;
  logic                      carry_half;
  logic                      ov_full;
  logic                      ov_half;
  logic                      ov_known;
  logic [3:0]                cr_calc;

  ifg_flags_t flg_q, flg_d;
  logic [3:0] cr_q, cr_d;
  logic       flg_ce, cr_ce;

  assign src_vec = {src_c, src_b, src_a};

  ifg_operand_list #(.XLEN(XLEN), .NSRC(NSRC)) u_list (
    .src       (src_vec),
    .src_cnt   (src_cnt),
    .inv_first (inv_first),
    .imm_vld   (imm_vld),
    .imm       (imm_val),
    .ent       (ent),
    .ent_vld   (ent_vld),
    .pair_x    (pair_x),
    .pair_y    (pair_y),
    .pair_ok   (pair_ok)
  );

  ifg_carry_detect #(.XLEN(XLEN), .NENT(NENT), .CW(XLEN)) u_carry_full (
    .ent     (ent),
    .ent_vld (ent_vld),
    .res     (result),
    .carry   (carry_full)
  );

  ifg_carry_detect #(.XLEN(XLEN), .NENT(NENT), .CW(XLEN / 2)) u_carry_half (
    .ent     (ent),
    .ent_vld (ent_vld),
    .res     (result),
    .carry   (carry_half)
  );

  ifg_ovf_detect #(.XLEN(XLEN)) u_ovf (
    .pair_x   (pair_x),
    .pair_y   (pair_y),
    .pair_ok  (pair_ok),
    .res      (result),
    .div_vld  (div_vld),
    .div_ovf  (div_ovf),
    .ov_full  (ov_full),
    .ov_half  (ov_half),
    .ov_known (ov_known)
  );

  ifg_cr_form #(.XLEN(XLEN)) u_cr (
    .res   (result),
    .so_in (flg_d.so),
    .cr    (cr_calc)
  );

  // next-state
  always_comb begin
    flg_d = flg_q;
    if (carry_en && !done_mask[IFG_DONE_CA]) begin
      flg_d.ca = carry_full;
    end
    if (carry_en && !done_mask[IFG_DONE_CA32]) begin
      flg_d.ca32 = carry_half;
    end
    if (oe_en && oe_vld && ov_known) begin
      flg_d.ov   = ov_full;
      flg_d.ov32 = ov_half;
      flg_d.so   = flg_q.so | ov_full;
    end
  end

  assign cr_d   = cr_calc;
  assign flg_ce = upd_en;
  assign cr_ce  = upd_en & rc_en;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      cr_q  <= '0;
    end else begin
      if (flg_ce) begin
        flg_q <= flg_d;
      end
      if (cr_ce) begin
        cr_q <= cr_d;
      end
    end
  end

  assign ca_o   = flg_q.ca;
  assign ca32_o = flg_q.ca32;
  assign ov_o   = flg_q.ov;
  assign ov32_o = flg_q.ov32;
  assign so_o   = flg_q.so;
  assign cr0_o  = cr_q;

endmodule

// File: rtl/ifg_flag_chk.sv
module ifg_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic       div_vld,
  input logic       div_ovf,
  input logic       carry_en,
  input logic       oe_en,
  input logic       oe_vld,
  input logic       rc_en,
  input logic [1:0] done_mask,
  input logic       ca_o,
  input logic       ca32_o,
  input logic       ov_o,
  input logic       ov32_o,
  input logic       so_o,
  input logic [3:0] cr0_o
);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}));

  // R5
  done_ca_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (done_mask[0] || !carry_en)) |=> $stable(ca_o));

  // R5
  done_ca32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (done_mask[1] || !carry_en)) |=> $stable(ca32_o));

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(oe_en && oe_vld)) |=> $stable({ov_o, ov32_o, so_o}));

  // R7
  div_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && oe_en && oe_vld && div_vld) |=>
      (ov_o == $past(div_ovf)) && (ov32_o == $past(div_ovf)));

  // R10
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_o |=> so_o);

  // R10
  ov_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o |-> so_o);

  // R11
  cr_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && rc_en) |=> ($countones(cr0_o[3:1]) == 1));

  // R11
  cr_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && rc_en) |=> (cr0_o[0] == so_o));

endmodule

bind int_flag_gen ifg_flag_chk u_ifg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_en    (upd_en),
  .div_vld   (div_vld),
  .div_ovf   (div_ovf),
  .carry_en  (carry_en),
  .oe_en     (oe_en),
  .oe_vld    (oe_vld),
  .rc_en     (rc_en),
  .done_mask (done_mask),
  .ca_o      (ca_o),
  .ca32_o    (ca32_o),
  .ov_o      (ov_o),
  .ov32_o    (ov32_o),
  .so_o      (so_o),
  .cr0_o     (cr0_o)
);

// File: tb/int_flag_gen_bench.sv
`timescale 1ns/1ps
module int_flag_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, inv_first, imm_vld, div_vld, div_ovf;
  logic        carry_en, oe_en, oe_vld, rc_en;
  logic [63:0] src_a, src_b, src_c, imm_val, result;
  logic [1:0]  src_cnt, done_mask;
  logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [3:0]  cr0_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_done = 0;

  bit       m_ca, m_ca32, m_ov, m_ov32, m_so;
  bit [3:0] m_cr;

  always #2.5 clk = ~clk;

  int_flag_gen u_int_flag_gen (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .src_cnt(src_cnt),
    .inv_first(inv_first), .imm_vld(imm_vld), .imm_val(imm_val),
    .result(result), .div_vld(div_vld), .div_ovf(div_ovf),
    .carry_en(carry_en), .oe_en(oe_en), .oe_vld(oe_vld), .rc_en(rc_en),
    .done_mask(done_mask),
    .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
    .so_o(so_o), .cr0_o(cr0_o)
  );

  task automatic cmp(string tag, string fld, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "ca",   {3'b0, ca_o},   {3'b0, m_ca});
    cmp(tag, "ca32", {3'b0, ca32_o}, {3'b0, m_ca32});
    cmp(tag, "ov",   {3'b0, ov_o},   {3'b0, m_ov});
    cmp(tag, "ov32", {3'b0, ov32_o}, {3'b0, m_ov32});
    cmp(tag, "so",   {3'b0, so_o},   {3'b0, m_so});
    cmp(tag, "cr0",  cr0_o,          m_cr);
  endtask

  // reference model of one update
  task automatic model_step();
    logic [63:0] e [4];
    bit v [4];
    bit c64, c32, have_x, have_y, ov_upd, n_ov, n_ov32, neg, zero;
    logic [63:0] x, y;
    if (!upd_en) return;
    e[0] = inv_first ? ~src_a : src_a; v[0] = (src_cnt >= 2'd1);
    e[1] = src_b;                      v[1] = (src_cnt >= 2'd2);
    e[2] = src_c;                      v[2] = (src_cnt == 2'd3);
    e[3] = imm_val;                    v[3] = imm_vld;
    c64 = 0; c32 = 0; have_x = 0; have_y = 0; x = '0; y = '0;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) begin
        if (e[i] > result) c64 = 1;
        if (e[i][31:0] > result[31:0]) c32 = 1;
        if (!have_x) begin x = e[i]; have_x = 1; end
        else if (!have_y) begin y = e[i]; have_y = 1; end
      end
    end
    if (carry_en && !done_mask[0]) m_ca = c64;
    if (carry_en && !done_mask[1]) m_ca32 = c32;
    ov_upd = 0; n_ov = 0; n_ov32 = 0;
    if (oe_en && oe_vld) begin
      if (div_vld) begin
        ov_upd = 1; n_ov = div_ovf; n_ov32 = div_ovf;
      end else if (have_y) begin
        ov_upd = 1;
        n_ov   = (x[63] == y[63]) && (result[63] != x[63]);
        n_ov32 = (x[31] == y[31]) && (result[31] != x[31]);
      end
    end
    if (ov_upd) begin
      m_ov = n_ov; m_ov32 = n_ov32; m_so = m_so | n_ov;
    end
    if (rc_en) begin
      neg  = result[63];
      zero = (result == 64'd0);
      m_cr = {neg, !neg && !zero, zero, m_so};
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle_inputs();
    upd_en = 0; inv_first = 0; imm_vld = 0; div_vld = 0; div_ovf = 0;
    carry_en = 0; oe_en = 0; oe_vld = 0; rc_en = 0; done_mask = 2'b00;
    src_a = '0; src_b = '0; src_c = '0; imm_val = '0; result = '0;
    src_cnt = 2'd0;
  endtask

  task automatic full_update(logic [1:0] cnt, logic [63:0] a, logic [63:0] b,
                             logic [63:0] r);
    idle_inputs();
    upd_en = 1; carry_en = 1; oe_en = 1; oe_vld = 1; rc_en = 1;
    src_cnt = cnt; src_a = a; src_b = b; result = r;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = 4'h0;
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);

    // R3 no carry, then carry from first operand
    full_update(2'd2, 64'd5, 64'd3, 64'd8);
    step("R3 no carry");
    full_update(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1);
    step("R3 carry set");

    // R4 low-half carry differs from full-width carry
    full_update(2'd2, 64'h0000_0000_FFFF_FFFF, 64'd1, 64'h0000_0001_0000_0000);
    step("R4 half carry only");

    // R2 inversion of first operand creates a carry
    full_update(2'd2, 64'd0, 64'd1, 64'd16);
    inv_first = 1;
    step("R2 inverted first");
    // R2 immediate appended as an entry
    full_update(2'd1, 64'd1, 64'd0, 64'd5);
    imm_vld = 1; imm_val = 64'd10;
    step("R2 immediate entry");
    // R2 src_c counted only with src_cnt 3
    full_update(2'd2, 64'd1, 64'd1, 64'd4);
    src_c = 64'hFF;
    step("R2 third excluded");
    full_update(2'd3, 64'd1, 64'd1, 64'd4);
    src_c = 64'hFF;
    step("R2 third included");

    // R5 done mask: suppress ca only, then ca32 only
    full_update(2'd2, 64'd1, 64'd1, 64'd2);
    done_mask = 2'b01;
    step("R5 ca suppressed");
    full_update(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    done_mask = 2'b10;
    step("R5 ca32 suppressed");
    full_update(2'd2, 64'd1, 64'd1, 64'd2);
    carry_en = 0;
    step("R5 carry disabled");

    // R6 full-width overflow only, then half-width only
    full_update(2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000);
    step("R6 ov64");
    full_update(2'd2, 64'h0000_0000_7FFF_FFFF, 64'd1, 64'h0000_0000_8000_0000);
    step("R6 ov32");
    // R6 pairing with immediate when only one source
    full_update(2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'h8000_0000_0000_0000);
    imm_vld = 1; imm_val = 64'd1;
    step("R6 imm pair");

    // R10 overflow clears, SO stays
    full_update(2'd2, 64'd1, 64'd2, 64'd3);
    step("R10 so sticky");

    // R7 divide overflow with no operands, then forced clear
    full_update(2'd0, 64'd0, 64'd0, 64'd0);
    div_vld = 1; div_ovf = 1;
    step("R7 div set");
    full_update(2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000);
    div_vld = 1; div_ovf = 0;
    step("R7 div clear");

    // R8 one operand, no divide: overflow untouched
    full_update(2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000);
    step("R8 prime");
    full_update(2'd1, 64'd3, 64'd0, 64'd3);
    step("R8 single operand");

    // R9 oe gating
    full_update(2'd2, 64'd1, 64'd2, 64'd3);
    oe_vld = 0;
    step("R9 oe not valid");
    full_update(2'd2, 64'd1, 64'd2, 64'd3);
    oe_en = 0;
    step("R9 oe disabled");

    // R11 condition classes
    full_update(2'd0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    step("R11 negative");
    full_update(2'd0, 64'd0, 64'd0, 64'd0);
    step("R11 zero");
    full_update(2'd0, 64'd0, 64'd0, 64'd42);
    step("R11 positive");

    // R12 inputs active but no update pulse
    full_update(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0);
    upd_en = 0; div_vld = 1; div_ovf = 0;
    step("R12 idle");

    // reset again, then random mix
    rst_n = 0;
    @(negedge clk);
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = 4'h0;
    check_all("R1 reset mid-run");
    rst_n = 1;
    for (int k = 0; k < 600; k++) begin
      idle_inputs();
      upd_en    = ($urandom % 8) != 0;
      src_cnt   = 2'($urandom);
      inv_first = ($urandom % 4) == 0;
      imm_vld   = ($urandom % 3) == 0;
      div_vld   = ($urandom % 6) == 0;
      div_ovf   = 1'($urandom);
      carry_en  = ($urandom % 4) != 0;
      oe_en     = ($urandom % 4) != 0;
      oe_vld    = ($urandom % 5) != 0;
      rc_en     = 1'($urandom);
      done_mask = 2'($urandom);
      src_a = rnd64(); src_b = rnd64(); src_c = rnd64(); imm_val = rnd64();
      if ($urandom % 2) begin
        src_a[63] = src_b[63];
        src_a[31] = src_b[31];
        result = src_a + src_b;
      end else if ($urandom % 4 == 0) begin
        result = '0;
      end else begin
        result = rnd64();
      end
      step("R3 R4 R6 R10 R11 random");
    end

    run_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule